// File: doc/BRIEF.md
# Power-Fail Deselect Sequencer

This block is the digital controller that sits between a battery-backed memory and its host bus while the supply comes and goes. It reads two comparator flags that are already synchronized to its clock. One says the supply is above the deselect threshold. The other says the supply is above the battery switchover threshold. From these it gates the host chip-enable and write-enable, gates the data-bus output enable, and selects battery power.

Protection takes effect in the same cycle that either flag drops. It is released only after a recovery wait of a programmable number of millisecond ticks, counted from the moment the deselect threshold is regained. Release also waits until the host chip-enable is inactive, so that no half-started cycle slips through. Each time the block leaves normal operation it emits a one-cycle pulse that clears the frequency-test bit. A two-bit state code is brought out for observation.

Top module: `pfail_seq`

## Requirements
- R1: While reset is asserted and after its release, the state code is RECOVERING (3), protection is active and the recovery count starts from zero.
- R2: In any cycle where the deselect flag is low, `wr_protect` is high in that same cycle. `mem_ce_n` and `mem_we_n` are then held at 1 and `dq_oe` at 0, whatever the bus inputs are. Writes and all bus inputs are therefore ignored.
- R3: The state code on `state_o` is NORMAL=0, DESELECTED=1, BATTERY=2, RECOVERING=3. A loss of the deselect flag in NORMAL gives DESELECTED at the next clock edge.
- R4: `bat_sel` is high in every cycle where the switchover flag is low, and low once that flag is high again. A low switchover flag moves the state to BATTERY at the next edge. When the flag returns, the state moves to DESELECTED, or to RECOVERING if the deselect flag is also high.
- R5: From DESELECTED, regaining the deselect flag moves the state to RECOVERING with the count at zero. Protection stays active until RECOVER_TICKS ticks have been counted. The state becomes NORMAL at the first edge after the final tick.
- R6: A loss of the deselect flag during RECOVERING returns the state to DESELECTED. The next recovery counts a full RECOVER_TICKS again.
- R7: Once the count is complete, the return to NORMAL waits while the host `ce_n` is low (active). It happens at the first edge with `ce_n` high.
- R8: `ft_clr` is high for exactly one cycle: the first cycle in which the state is no longer NORMAL after having been NORMAL.
- R9: In NORMAL, with both flags high, `mem_ce_n` equals `ce_n` and `mem_we_n` equals `we_n`. `dq_oe` is high exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_ok | input | 1 | Supply above deselect threshold (synchronized) |
| vcc_sw | input | 1 | Supply above battery switchover threshold (synchronized) |
| tick | input | 1 | One-cycle millisecond tick |
| ce_n | input | 1 | Host chip-enable, active low |
| we_n | input | 1 | Host write-enable, active low |
| oe_n | input | 1 | Host output-enable, active low |
| mem_ce_n | output | 1 | Gated chip-enable to the memory |
| mem_we_n | output | 1 | Gated write-enable to the memory |
| dq_oe | output | 1 | Data bus output-drive enable |
| wr_protect | output | 1 | Write-protect / deselect indication |
| bat_sel | output | 1 | Select battery power |
| ft_clr | output | 1 | One-cycle clear of the frequency-test bit |
| state_o | output | 2 | Current state code |

## Verification
The gating outputs `wr_protect`, `mem_ce_n`, `mem_we_n`, `dq_oe` and `bat_sel` respond within the same cycle as a flag change. The bench drives the flags just after a falling edge and samples these outputs one time unit later, before any rising edge. The state code and `ft_clr` change at the first rising edge after the stimulus, so they are sampled at the following falling edge. Ticks are single-cycle pulses, each consumed at one rising edge. After the last of RECOVER_TICKS ticks the state is still RECOVERING, and NORMAL is checked one falling edge later.

// File: rtl/pfail_seq.sv
module pfail_seq #(
  parameter int RECOVER_TICKS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_ok,
  input  logic       vcc_sw,
  input  logic       tick,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic       oe_n,
  output logic       mem_ce_n,
  output logic       mem_we_n,
  output logic       dq_oe,
  output logic       wr_protect,
  output logic       bat_sel,
  output logic       ft_clr,
  output logic [1:0] state_o
);
  localparam int CW = $clog2(RECOVER_TICKS + 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(RECOVER_TICKS);

  localparam logic [1:0] S_NORM = 2'd0;
  localparam logic [1:0] S_DESEL = 2'd1;
  localparam logic [1:0] S_BAT = 2'd2;
  localparam logic [1:0] S_REC = 2'd3;

  logic [1:0]    state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          ft_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_NORM:  if (!vcc_sw) state_d = S_BAT;
               else if (!vcc_ok) state_d = S_DESEL;
      S_DESEL: if (!vcc_sw) state_d = S_BAT;
               else if (vcc_ok) state_d = S_REC;
      S_BAT:   if (vcc_sw) state_d = vcc_ok ? S_REC : S_DESEL;
      default: if (!vcc_sw) state_d = S_BAT;
               else if (!vcc_ok) state_d = S_DESEL;
               else if (cnt_q == CNT_DONE && ce_n) state_d = S_NORM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_REC;
      cnt_q   <= '0;
      ft_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ft_q    <= (state_q == S_NORM) && (state_d != S_NORM);
      if (state_d == S_REC && state_q != S_REC)
        cnt_q <= '0;
      else if (state_q == S_REC && tick && cnt_q != CNT_DONE)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign wr_protect = (state_q != S_NORM) || !vcc_ok || !vcc_sw;
  assign mem_ce_n   = ce_n | wr_protect;
  assign mem_we_n   = we_n | wr_protect;
  assign dq_oe      = !wr_protect && !ce_n && !oe_n && we_n;
  assign bat_sel    = !vcc_sw;
  assign ft_clr     = ft_q;
  assign state_o    = state_q;

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok |-> (mem_ce_n && mem_we_n && !dq_oe));
  p_desel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_NORM && vcc_sw && !vcc_ok) |=> state_o == S_DESEL);
  p_bat_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_sw |=> state_o == S_BAT);
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_NORM && $past(state_o) == S_REC) |-> $past(cnt_q) == CNT_DONE);
  p_idle_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_NORM && $past(state_o) != S_NORM) |-> $past(ce_n));
  p_ftpulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != S_NORM && $past(state_o) == S_NORM) |-> ft_clr);
  p_ftone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ft_clr |=> !ft_clr);
endmodule

// File: tb/pfail_seq_test.sv
module pfail_seq_test;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic vcc_ok = 1, vcc_sw = 1, tick = 0, ce_n = 1, we_n = 1, oe_n = 1;
  logic mem_ce_n, mem_we_n, dq_oe, wr_protect, bat_sel, ft_clr;
  logic [1:0] state_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  pfail_seq #(.RECOVER_TICKS(N)) uut (
    .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .vcc_sw(vcc_sw), .tick(tick),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .dq_oe(dq_oe), .wr_protect(wr_protect),
    .bat_sel(bat_sel), .ft_clr(ft_clr), .state_o(state_o));

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic give_ticks(int k);
    for (int i = 0; i < k; i++) begin
      tick = 1; step(); tick = 0;
    end
  endtask

  task automatic t_reset_r1();
    step(); step();
    chk("R1 state in reset", state_o, 3);
    rst_n = 1; step();
    chk("R1 state after reset", state_o, 3);
    chk("R1 protect", wr_protect, 1);
    give_ticks(N - 1);
    chk("R1 count from zero", state_o, 3);
    give_ticks(1); step();
    chk("R1 normal after N ticks", state_o, 0);
  endtask

  task automatic t_normal_r9();
    ce_n = 0; oe_n = 0; we_n = 1; #1;
    chk("R9 read dq_oe", dq_oe, 1);
    chk("R9 mem_ce_n", mem_ce_n, 0);
    we_n = 0; #1;
    chk("R9 mem_we_n", mem_we_n, 0);
    chk("R9 no oe on write", dq_oe, 0);
    ce_n = 1; we_n = 1; oe_n = 1; step();
  endtask

  task automatic t_loss_r2_r3_r8();
    ce_n = 0; we_n = 0; oe_n = 0; vcc_ok = 0; #1;
    chk("R2 protect same cycle", wr_protect, 1);
    chk("R2 we blocked", mem_we_n, 1);
    chk("R2 ce blocked", mem_ce_n, 1);
    chk("R2 dq hi-z", dq_oe, 0);
    step();
    chk("R3 deselected", state_o, 1);
    chk("R8 ft_clr pulse", ft_clr, 1);
    step();
    chk("R8 ft_clr one cycle", ft_clr, 0);
    ce_n = 1; we_n = 1; oe_n = 1;
  endtask

  task automatic t_battery_r4();
    vcc_sw = 0; #1;
    chk("R4 bat_sel immediate", bat_sel, 1);
    step();
    chk("R4 battery state", state_o, 2);
    vcc_sw = 1; #1;
    chk("R4 bat_sel released", bat_sel, 0);
    step();
    chk("R4 back to deselected", state_o, 1);
  endtask

  task automatic t_recover_r5_r6();
    vcc_ok = 1; step();
    chk("R5 recovering", state_o, 3);
    give_ticks(2);
    vcc_ok = 0; step();
    chk("R6 loss returns deselected", state_o, 1);
    vcc_ok = 1; step();
    chk("R6 recovering again", state_o, 3);
    give_ticks(N - 1);
    #1 chk("R6 full count restarts", wr_protect, 1);
    give_ticks(1);
    chk("R5 still protected at last tick", state_o, 3);
    step();
    chk("R5 normal after count", state_o, 0);
    chk("R5 protect released", wr_protect, 0);
  endtask

  task automatic t_ce_wait_r7();
    vcc_ok = 0; step(); vcc_ok = 1; step();
    ce_n = 0;
    give_ticks(N); step(); step();
    chk("R7 waits while ce_n low", state_o, 3);
    ce_n = 1; step();
    chk("R7 normal once ce_n high", state_o, 0);
  endtask

  initial begin
    fork
      begin
        t_reset_r1();
        t_normal_r9();
        t_loss_r2_r3_r8();
        t_battery_r4();
        t_recover_r5_r6();
        t_ce_wait_r7();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule